// File: doc/BRIEF.md
# Primitive Repetition Suppression Unit

This block sits in the link layer of a serial storage interface. It lies between the link state machine and the line encoder. On the transmit path it watches a stream of 32-bit link words, each flagged as either a primitive or data. When the state machine asks for the same primitive over and over, the block sends that primitive a small number of times. It then sends one continuation primitive, and after that it sends pseudo-random filler words. The filler keeps the line from carrying a strictly periodic pattern, which lowers the peaks in the emitted spectrum.

On the receive path the block does the reverse. After a continuation primitive it drops every filler word from the payload stream, and it reports the primitive being repeated on a sideband output. It stops doing this when a different primitive arrives. The line alignment primitive belongs to the physical layer and is transparent to both paths. The block does not forward it upward, and it never breaks or restarts a run.

Both paths are combinational pass-through stages with a valid/ready handshake. The internal state advances only on an accepted word. A resynchronisation input clears all repeat tracking, for example after a link reset or a loss of lock.

Top module: `prim_run_suppress`

States and transitions. The transmit machine has three states:
- TX_IDLE: nothing is being tracked.
- TX_REPEAT: the block is counting sends of the held primitive.
- TX_FILL: the continuation has been sent and filler is going out.

Its transitions are:
- idle-to-repeat when a primitive is accepted.
- repeat-to-repeat when the same primitive is accepted below the limit, or a different one is accepted.
- repeat-to-fill when the same primitive is accepted at the limit. The continuation is emitted on this word.
- fill-to-fill when the same primitive is accepted again. A filler word is emitted.
- fill-to-repeat when a different primitive is accepted.
- any state to idle on a data word or a resync.

The receive machine also has three states:
- RX_IDLE: no primitive is held.
- RX_HELD: the last primitive is held.
- RX_RUN: the block is inside a suppressed run.

Its transitions are:
- idle or held to held when a new primitive is accepted.
- held-to-run when a continuation is accepted.
- run-to-held when a different primitive is accepted.
- idle or held to idle when a data word is accepted.
- any state to idle on a resync.

## Requirements
- R1: A transmit word flagged as data (flag 0) leaves unchanged, with flag 0, in the same cycle. It clears repeat tracking, so the next primitive is treated as a first send.
- R2: A requested primitive is sent unchanged on its first and second consecutive accepted requests (REP_MIN = 2).
- R3: On the third consecutive accepted request of the same primitive, the output is the continuation code (default 32'h5A5A_A57C) with flag 1. Every later consecutive request of that primitive gives a filler word with flag 0.
- R4: During counting or filling, a primitive that differs from the held one is sent unchanged and counts as its first send.
- R5: The alignment code (default 32'h3C3C_C3BC, flag 1) passes through the transmit path unchanged and leaves the count and the run untouched. For example, P, align, P, P yields P, align, P, continuation.
- R6: On each path, ready in follows ready out, and valid out follows valid in, in the same cycle. State changes only on a word accepted with valid and ready both high.
- R7: Consecutive accepted filler words differ. They come from a 16-bit LFSR that steps once per accepted filler word.
- R8: On receive, a primitive that is neither the alignment nor the continuation code, and is not a repeat of the held primitive during a run, is forwarded unchanged and becomes the held primitive.
- R9: On receive, a continuation arriving while a primitive is held is not forwarded. It starts a run, during which rx_rep_active is 1 and rx_rep_word shows the held primitive. A continuation arriving with no primitive held is dropped and starts no run.
- R10: During a run, data-flagged words and repeats of the held primitive are not forwarded. A different primitive is forwarded and ends the run.
- R11: A received alignment code is never forwarded. It does not change the held primitive or the run.
- R12: A received data word outside a run is forwarded unchanged and clears the held primitive, so a continuation that follows it starts no run.
- R13: After reset, and in the cycle after link_resync is high, no run is active and no count is held. Resync takes priority over a word accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| link_resync | input | 1 | Clears all repeat tracking |
| tx_in_valid | input | 1 | Transmit request word valid |
| tx_in_ready | output | 1 | Transmit request accepted |
| tx_in_word | input | 32 | Requested link word |
| tx_in_is_prim | input | 1 | Requested word is a primitive |
| tx_out_valid | output | 1 | Encoder-side word valid |
| tx_out_ready | input | 1 | Encoder accepts word |
| tx_out_word | output | 32 | Word sent to encoder |
| tx_out_is_prim | output | 1 | Sent word is a primitive |
| rx_in_valid | input | 1 | Decoded word valid |
| rx_in_ready | output | 1 | Decoded word accepted |
| rx_in_word | input | 32 | Decoded link word |
| rx_in_is_prim | input | 1 | Decoded word is a primitive |
| rx_out_valid | output | 1 | Payload word valid toward link state machine |
| rx_out_ready | input | 1 | Link state machine accepts word |
| rx_out_word | output | 32 | Payload word |
| rx_out_is_prim | output | 1 | Payload word is a primitive |
| rx_rep_active | output | 1 | A suppressed run is in progress |
| rx_rep_word | output | 32 | Primitive being repeated during a run |

## Verification
A wrong transmit count shows up at most three accepted words after a primitive change. It appears either as a continuation emitted too early, or as a real primitive emitted where the continuation belongs. A wrong fill state shows up on the very next accepted word as a flagged primitive where a filler word should be. On receive, a stuck run state is visible at once on rx_rep_active. It also appears as a dropped data or primitive word on the next accepted input. A missed run appears as filler leaking into the payload stream on the word after the continuation. The stimulus mixes long runs, alignment words in the middle of runs, stalls on ready and resyncs, so each of these slips reaches a port within a few cycles.

// File: rtl/prs_pkg.sv
package prs_pkg;

    localparam int WORD_W = 32;
    localparam int LFSR_W = 16;

    typedef enum logic [1:0] {
        TX_IDLE   = 2'd0,
        TX_REPEAT = 2'd1,
        TX_FILL   = 2'd2
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_HELD = 2'd1,
        RX_RUN  = 2'd2
    } rx_state_e;

endpackage

// File: rtl/prs_lfsr16.sv
module prs_lfsr16 #(
    parameter int                      WORD_W = prs_pkg::WORD_W,
    parameter int                      LFSR_W = prs_pkg::LFSR_W,
    parameter logic [LFSR_W-1:0]       SEED   = 16'hFFFF,
    parameter logic [LFSR_W-1:0]       TAPS   = 16'hF009
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    output logic [WORD_W-1:0] fill_word
);
    localparam int COPIES = WORD_W / LFSR_W;

    logic [LFSR_W-1:0] q;
    logic              fb;

    assign fb = ^(q & TAPS);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= SEED;
        end else if (clear) begin
            q <= SEED;
        end else if (step) begin
            q <= {q[LFSR_W-2:0], fb};
        end
    end

    // Spread the register across the word, every other copy inverted
    // so the filler word has no long constant byte lanes.
    for (genvar g = 0; g < COPIES; g++) begin : g_lane
        if (g % 2 == 1) begin : g_inv
            assign fill_word[g*LFSR_W +: LFSR_W] = ~q;
        end else begin : g_true
            assign fill_word[g*LFSR_W +: LFSR_W] = q;
        end
    end

endmodule

// File: rtl/prs_tx_fsm.sv
module prs_tx_fsm
    import prs_pkg::*;
#(
    parameter logic [WORD_W-1:0] CONT_CODE  = 32'h5A5A_A57C,
    parameter logic [WORD_W-1:0] ALIGN_CODE = 32'h3C3C_C3BC,
    parameter int                REP_MIN    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              resync,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_is_prim,
    input  logic              out_ready,
    input  logic [WORD_W-1:0] fill_word,
    output logic [WORD_W-1:0] out_word,
    output logic              out_is_prim,
    output logic              fill_step
);
    localparam int              CNT_W   = $clog2(REP_MIN + 1);
    localparam logic [CNT_W-1:0] REP_LIM = CNT_W'(REP_MIN);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    tx_state_e         state_q, state_d;
    logic [WORD_W-1:0] held_q, held_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;

    logic fire, is_align, tracked, same;

    assign fire     = in_valid && out_ready;
    assign is_align = in_is_prim && (in_word == ALIGN_CODE);
    assign tracked  = in_is_prim && !is_align;
    assign same     = (state_q != TX_IDLE) && (in_word == held_q);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n || resync) begin
            state_q <= TX_IDLE;
            held_q  <= '0;
            cnt_q   <= '0;
        end else if (fire) begin
            state_q <= state_d;
            held_q  <= held_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        held_d  = held_q;
        cnt_d   = cnt_q;
        if (!in_is_prim) begin
            state_d = TX_IDLE;
            cnt_d   = '0;
        end else if (tracked) begin
            if (!same) begin
                state_d = TX_REPEAT;
                held_d  = in_word;
                cnt_d   = ONE;
            end else begin
                unique case (state_q)
                    TX_REPEAT: begin
                        if (cnt_q < REP_LIM) begin
                            cnt_d = cnt_q + ONE;
                        end else begin
                            state_d = TX_FILL;
                        end
                    end
                    TX_FILL: state_d = TX_FILL;
                    default: state_d = TX_REPEAT;
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        out_word    = in_word;
        out_is_prim = in_is_prim;
        fill_step   = 1'b0;
        if (tracked && same) begin
            unique case (state_q)
                TX_REPEAT: begin
                    if (cnt_q >= REP_LIM) begin
                        out_word = CONT_CODE;
                    end
                end
                TX_FILL: begin
                    out_word    = fill_word;
                    out_is_prim = 1'b0;
                    fill_step   = fire;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/prs_rx_fsm.sv
module prs_rx_fsm
    import prs_pkg::*;
#(
    parameter logic [WORD_W-1:0] CONT_CODE  = 32'h5A5A_A57C,
    parameter logic [WORD_W-1:0] ALIGN_CODE = 32'h3C3C_C3BC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              resync,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_is_prim,
    input  logic              out_ready,
    output logic              out_valid,
    output logic              rep_active,
    output logic [WORD_W-1:0] rep_word
);
    rx_state_e         state_q, state_d;
    logic [WORD_W-1:0] held_q, held_d;
    logic              fire, is_align, is_cont, pass;

    assign fire     = in_valid && out_ready;
    assign is_align = in_is_prim && (in_word == ALIGN_CODE);
    assign is_cont  = in_is_prim && (in_word == CONT_CODE);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n || resync) begin
            state_q <= RX_IDLE;
            held_q  <= '0;
        end else if (fire) begin
            state_q <= state_d;
            held_q  <= held_d;
        end
    end

    // Next state and forwarding decision
    always_comb begin
        state_d = state_q;
        held_d  = held_q;
        pass    = 1'b1;
        if (is_align) begin
            pass = 1'b0;
        end else if (is_cont) begin
            pass = 1'b0;
            if (state_q == RX_HELD) begin
                state_d = RX_RUN;
            end
        end else if (in_is_prim) begin
            if (state_q == RX_RUN && in_word == held_q) begin
                pass = 1'b0;
            end else begin
                state_d = RX_HELD;
                held_d  = in_word;
            end
        end else begin
            unique case (state_q)
                RX_RUN:  pass = 1'b0;
                default: begin
                    state_d = RX_IDLE;
                    held_d  = '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        out_valid  = in_valid && pass;
        rep_active = (state_q == RX_RUN);
        rep_word   = held_q;
    end

endmodule

// File: rtl/prim_run_suppress.sv
module prim_run_suppress #(
    parameter logic [31:0] CONT_CODE  = 32'h5A5A_A57C,
    parameter logic [31:0] ALIGN_CODE = 32'h3C3C_C3BC,
    parameter int          REP_MIN    = 2,
    parameter logic [15:0] FILL_SEED  = 16'hFFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        link_resync,
    input  logic        tx_in_valid,
    output logic        tx_in_ready,
    input  logic [31:0] tx_in_word,
    input  logic        tx_in_is_prim,
    output logic        tx_out_valid,
    input  logic        tx_out_ready,
    output logic [31:0] tx_out_word,
    output logic        tx_out_is_prim,
    input  logic        rx_in_valid,
    output logic        rx_in_ready,
    input  logic [31:0] rx_in_word,
    input  logic        rx_in_is_prim,
    output logic        rx_out_valid,
    input  logic        rx_out_ready,
    output logic [31:0] rx_out_word,
    output logic        rx_out_is_prim,
    output logic        rx_rep_active,
    output logic [31:0] rx_rep_word
);
    import prs_pkg::*;

    logic [WORD_W-1:0] fill_word;
    logic              fill_step;

    assign tx_in_ready    = tx_out_ready;
    assign tx_out_valid   = tx_in_valid;
    assign rx_in_ready    = rx_out_ready;
    assign rx_out_word    = rx_in_word;
    assign rx_out_is_prim = rx_in_is_prim;

    prs_lfsr16 #(
        .SEED (FILL_SEED)
    ) u_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (link_resync),
        .step      (fill_step),
        .fill_word (fill_word)
    );

    prs_tx_fsm #(
        .CONT_CODE  (CONT_CODE),
        .ALIGN_CODE (ALIGN_CODE),
        .REP_MIN    (REP_MIN)
    ) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .resync      (link_resync),
        .in_valid    (tx_in_valid),
        .in_word     (tx_in_word),
        .in_is_prim  (tx_in_is_prim),
        .out_ready   (tx_out_ready),
        .fill_word   (fill_word),
        .out_word    (tx_out_word),
        .out_is_prim (tx_out_is_prim),
        .fill_step   (fill_step)
    );

    prs_rx_fsm #(
        .CONT_CODE  (CONT_CODE),
        .ALIGN_CODE (ALIGN_CODE)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .resync     (link_resync),
        .in_valid   (rx_in_valid),
        .in_word    (rx_in_word),
        .in_is_prim (rx_in_is_prim),
        .out_ready  (rx_out_ready),
        .out_valid  (rx_out_valid),
        .rep_active (rx_rep_active),
        .rep_word   (rx_rep_word)
    );

endmodule

// File: rtl/prs_checker.sv
module prs_checker #(
    parameter logic [31:0] CONT_CODE  = 32'h5A5A_A57C,
    parameter logic [31:0] ALIGN_CODE = 32'h3C3C_C3BC,
    parameter int          REP_MIN    = 2
) (
    input logic        clk,
    input logic        rst_n,
    input logic        link_resync,
    input logic        tx_in_valid,
    input logic [31:0] tx_in_word,
    input logic        tx_in_is_prim,
    input logic        tx_out_valid,
    input logic        tx_out_ready,
    input logic [31:0] tx_out_word,
    input logic        tx_out_is_prim,
    input logic        rx_in_valid,
    input logic [31:0] rx_in_word,
    input logic        rx_in_is_prim,
    input logic        rx_out_valid,
    input logic        rx_rep_active
);
    logic [7:0]  seen_cnt;
    logic [31:0] seen_word;
    logic        tx_fire;

    assign tx_fire = tx_out_valid && tx_out_ready;

    // Count identical primitives actually emitted toward the encoder.
    always_ff @(posedge clk) begin
        if (!rst_n || link_resync) begin
            seen_cnt  <= '0;
            seen_word <= '0;
        end else if (tx_fire) begin
            if (!tx_out_is_prim) begin
                seen_cnt <= '0;
            end else if (tx_out_word == ALIGN_CODE || tx_out_word == CONT_CODE) begin
                seen_cnt <= seen_cnt;
            end else if (seen_cnt != 8'd0 && tx_out_word == seen_word) begin
                if (seen_cnt != 8'hFF) seen_cnt <= seen_cnt + 8'd1;
            end else begin
                seen_word <= tx_out_word;
                seen_cnt  <= 8'd1;
            end
        end
    end

    // R1
    data_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_in_valid && !tx_in_is_prim) |-> (tx_out_word == tx_in_word && !tx_out_is_prim));

    // R3
    cont_after_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_fire && tx_out_is_prim && tx_out_word == CONT_CODE) |-> (seen_cnt >= 8'(REP_MIN)));

    // R5
    align_tx_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_in_valid && tx_in_is_prim && tx_in_word == ALIGN_CODE)
            |-> (tx_out_is_prim && tx_out_word == ALIGN_CODE));

    // R10
    filler_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rep_active && rx_in_valid && !rx_in_is_prim) |-> !rx_out_valid);

    // R11
    align_rx_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_in_is_prim && rx_in_word == ALIGN_CODE) |-> !rx_out_valid);

    // R13
    resync_clears_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_resync |=> !rx_rep_active);

endmodule

bind prim_run_suppress prs_checker #(
    .CONT_CODE  (CONT_CODE),
    .ALIGN_CODE (ALIGN_CODE),
    .REP_MIN    (REP_MIN)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .link_resync    (link_resync),
    .tx_in_valid    (tx_in_valid),
    .tx_in_word     (tx_in_word),
    .tx_in_is_prim  (tx_in_is_prim),
    .tx_out_valid   (tx_out_valid),
    .tx_out_ready   (tx_out_ready),
    .tx_out_word    (tx_out_word),
    .tx_out_is_prim (tx_out_is_prim),
    .rx_in_valid    (rx_in_valid),
    .rx_in_word     (rx_in_word),
    .rx_in_is_prim  (rx_in_is_prim),
    .rx_out_valid   (rx_out_valid),
    .rx_rep_active  (rx_rep_active)
);

// File: tb/prim_run_suppress_tb_top.sv
module prim_run_suppress_tb_top;

    localparam logic [31:0] CONT  = 32'h5A5A_A57C;
    localparam logic [31:0] ALIGN = 32'h3C3C_C3BC;
    localparam logic [31:0] PA    = 32'h1122_33BC;
    localparam logic [31:0] PB    = 32'h4455_667C;
    localparam int          RMIN  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        link_resync = 1'b0;
    logic        tx_in_valid = 1'b0, tx_in_is_prim = 1'b0, tx_out_ready = 1'b0;
    logic [31:0] tx_in_word = '0;
    logic        tx_in_ready, tx_out_valid, tx_out_is_prim;
    logic [31:0] tx_out_word;
    logic        rx_in_valid = 1'b0, rx_in_is_prim = 1'b0, rx_out_ready = 1'b0;
    logic [31:0] rx_in_word = '0;
    logic        rx_in_ready, rx_out_valid, rx_out_is_prim, rx_rep_active;
    logic [31:0] rx_out_word, rx_rep_word;

    always #4 clk = ~clk;

    prim_run_suppress dut_i (
        .clk(clk), .rst_n(rst_n), .link_resync(link_resync),
        .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready),
        .tx_in_word(tx_in_word), .tx_in_is_prim(tx_in_is_prim),
        .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready),
        .tx_out_word(tx_out_word), .tx_out_is_prim(tx_out_is_prim),
        .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready),
        .rx_in_word(rx_in_word), .rx_in_is_prim(rx_in_is_prim),
        .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready),
        .rx_out_word(rx_out_word), .rx_out_is_prim(rx_out_is_prim),
        .rx_rep_active(rx_rep_active), .rx_rep_word(rx_rep_word)
    );

    int checks = 0;
    int errors = 0;

    // Reference state, derived from the requirements
    int          m_state;   // 0 idle, 1 counting, 2 filling
    logic [31:0] m_held;
    int          m_cnt;
    logic [31:0] last_fill;
    bit          have_fill;
    int          r_state;   // 0 none held, 1 held, 2 run
    logic [31:0] r_held;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_state = 0; m_held = '0; m_cnt = 0; have_fill = 1'b0;
        r_state = 0; r_held = '0;
    endtask

    // 0 = pass through, 1 = continuation, 2 = filler
    function automatic int tx_kind(input bit p, input logic [31:0] w);
        if (!p || w == ALIGN) return 0;
        if (m_state == 0 || w != m_held) return 0;
        if (m_state == 1) return (m_cnt < RMIN) ? 0 : 1;
        return 2;
    endfunction

    function automatic string tx_req(input bit p, input logic [31:0] w);
        if (!p) return "R1 data pass";
        if (w == ALIGN) return "R5 align pass";
        if (m_state == 0 || w != m_held) return "R4 new primitive";
        return "R2 early repeat";
    endfunction

    task automatic tx_update(input bit p, input logic [31:0] w);
        if (!p) begin
            m_state = 0; m_cnt = 0;
        end else if (w == ALIGN) begin
            m_state = m_state;
        end else if (m_state == 0 || w != m_held) begin
            m_state = 1; m_held = w; m_cnt = 1;
        end else if (m_state == 1) begin
            if (m_cnt < RMIN) m_cnt++;
            else m_state = 2;
        end
    endtask

    function automatic bit rx_pass(input bit p, input logic [31:0] w);
        if (p) begin
            if (w == ALIGN || w == CONT) return 1'b0;
            if (r_state == 2 && w == r_held) return 1'b0;
            return 1'b1;
        end
        return (r_state != 2);
    endfunction

    function automatic string rx_req(input bit p, input logic [31:0] w);
        if (p && w == ALIGN) return "R11 align dropped";
        if (p && w == CONT) return "R9 continuation";
        if (r_state == 2) return "R10 inside run";
        if (!p) return "R12 data outside run";
        return "R8 primitive forward";
    endfunction

    task automatic rx_update(input bit p, input logic [31:0] w);
        if (p) begin
            if (w == ALIGN) r_state = r_state;
            else if (w == CONT) begin
                if (r_state == 1) r_state = 2;
            end else if (r_state == 2 && w == r_held) r_state = 2;
            else begin r_state = 1; r_held = w; end
        end else if (r_state != 2) begin
            r_state = 0; r_held = '0;
        end
    endtask

    task automatic cycle(input bit rs,
                         input bit tv, input logic [31:0] tw, input bit tp, input bit tr,
                         input bit rv, input logic [31:0] rw, input bit rp, input bit rr);
        int          k;
        bit          exp_v;
        logic [31:0] cur_fill;
        @(negedge clk);
        link_resync = rs;
        tx_in_valid = tv; tx_in_word = tw; tx_in_is_prim = tp; tx_out_ready = tr;
        rx_in_valid = rv; rx_in_word = rw; rx_in_is_prim = rp; rx_out_ready = rr;
        #1;
        k = tx_kind(tp, tw);
        cur_fill = tx_out_word;
        chk(tx_in_ready == tr, "R6 tx ready follows", 32'(tx_in_ready), 32'(tr));
        chk(tx_out_valid == tv, "R6 tx valid follows", 32'(tx_out_valid), 32'(tv));
        if (tv) begin
            case (k)
                0: begin
                    chk(tx_out_word == tw, tx_req(tp, tw), tx_out_word, tw);
                    chk(tx_out_is_prim == tp, tx_req(tp, tw), 32'(tx_out_is_prim), 32'(tp));
                end
                1: begin
                    chk(tx_out_word == CONT, "R3 continuation word", tx_out_word, CONT);
                    chk(tx_out_is_prim, "R3 continuation flag", 32'(tx_out_is_prim), 32'd1);
                end
                default: begin
                    chk(!tx_out_is_prim, "R3 filler flag", 32'(tx_out_is_prim), 32'd0);
                    if (have_fill)
                        chk(tx_out_word != last_fill, "R7 filler changes", tx_out_word, last_fill);
                end
            endcase
        end
        chk(rx_in_ready == rr, "R6 rx ready follows", 32'(rx_in_ready), 32'(rr));
        exp_v = rv && rx_pass(rp, rw);
        chk(rx_out_valid == exp_v, rx_req(rp, rw), 32'(rx_out_valid), 32'(exp_v));
        if (exp_v)
            chk(rx_out_word == rw && rx_out_is_prim == rp, rx_req(rp, rw), rx_out_word, rw);
        chk(rx_rep_active == (r_state == 2), "R9 run flag", 32'(rx_rep_active), 32'(r_state == 2));
        if (r_state == 2)
            chk(rx_rep_word == r_held, "R9 held word", rx_rep_word, r_held);
        @(posedge clk);
        if (rs) begin
            model_reset();
        end else begin
            if (tv && tr) begin
                if (k == 2) begin last_fill = cur_fill; have_fill = 1'b1; end
                tx_update(tp, tw);
            end
            if (rv && rr) rx_update(rp, rw);
        end
    endtask

    task automatic txw(input logic [31:0] w, input bit p);
        cycle(1'b0, 1'b1, w, p, 1'b1, 1'b0, '0, 1'b0, 1'b1);
    endtask

    task automatic rxw(input logic [31:0] w, input bit p);
        cycle(1'b0, 1'b0, '0, 1'b0, 1'b1, 1'b1, w, p, 1'b1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [31:0] tlast, rlast;
        bit          tlp, rlp;
        void'($urandom(32'h5EED_0011));
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        chk(!rx_rep_active, "R13 reset no run", 32'(rx_rep_active), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2/R3/R7: long run of one primitive, then a change (R4)
        repeat (6) txw(PA, 1'b1);
        txw(PB, 1'b1);
        // R5: alignment inside the count
        txw(PA, 1'b1); txw(ALIGN, 1'b1); txw(PA, 1'b1); txw(PA, 1'b1);
        txw(ALIGN, 1'b1); txw(PA, 1'b1);
        // R1: data ends the run, count restarts
        txw(32'hDEAD_BEEF, 1'b0); txw(PA, 1'b1); txw(PA, 1'b1); txw(PA, 1'b1);
        // R6: stalled request does not advance
        cycle(1'b0, 1'b1, PB, 1'b1, 1'b0, 1'b0, '0, 1'b0, 1'b1);
        txw(PB, 1'b1); txw(PB, 1'b1); txw(PB, 1'b1);
        // R13: resync with a word offered in the same cycle
        cycle(1'b1, 1'b1, PB, 1'b1, 1'b1, 1'b0, '0, 1'b0, 1'b1);
        txw(PB, 1'b1); txw(PB, 1'b1); txw(PB, 1'b1);

        // Receive: R8/R9/R10/R11
        rxw(PA, 1'b1); rxw(CONT, 1'b1); rxw(32'h0BAD_F00D, 1'b0);
        rxw(PA, 1'b1); rxw(ALIGN, 1'b1); rxw(32'h1234_5678, 1'b0);
        rxw(PB, 1'b1);
        // R9: continuation with nothing held; R12: data clears held
        rxw(32'h0000_0042, 1'b0); rxw(CONT, 1'b1); rxw(32'h0000_0043, 1'b0);
        rxw(PA, 1'b1); rxw(CONT, 1'b1);
        // R13: resync ends the run
        cycle(1'b1, 1'b0, '0, 1'b0, 1'b1, 1'b0, '0, 1'b0, 1'b1);
        rxw(32'h7777_0000, 1'b0);

        // Constrained random mix on both paths
        tlast = PA; tlp = 1'b1; rlast = PA; rlp = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            int          tsel, rsel;
            logic [31:0] tw, rw;
            bit          tp, rp, rs;
            tsel = int'($urandom % 100);
            if (tsel < 55 && tlp)      begin tw = tlast; tp = 1'b1; end
            else if (tsel < 70)        begin tw = PA;    tp = 1'b1; end
            else if (tsel < 80)        begin tw = PB;    tp = 1'b1; end
            else if (tsel < 88)        begin tw = ALIGN; tp = 1'b1; end
            else                       begin tw = $urandom; tp = 1'b0; end
            rsel = int'($urandom % 100);
            if (rsel < 35)             begin rw = $urandom; rp = 1'b0; end
            else if (rsel < 50 && rlp) begin rw = rlast; rp = 1'b1; end
            else if (rsel < 65)        begin rw = CONT;  rp = 1'b1; end
            else if (rsel < 78)        begin rw = PA;    rp = 1'b1; end
            else if (rsel < 90)        begin rw = PB;    rp = 1'b1; end
            else                       begin rw = ALIGN; rp = 1'b1; end
            rs = (($urandom % 100) == 0);
            cycle(rs, ($urandom % 100) < 85, tw, tp, ($urandom % 100) < 80,
                      ($urandom % 100) < 85, rw, rp, ($urandom % 100) < 80);
            if (tp && tw != ALIGN) begin tlast = tw; end
            tlp = tp;
            if (rp && rw != ALIGN && rw != CONT) begin rlast = rw; end
            rlp = rp;
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule